// File: doc/BRIEF.md
# Cycle-Timed Validation Coprocessor

A test coprocessor that sits beside a host core and gives test programs control over time and interrupts. It owns a bank of sixteen 32-bit registers. The host moves data in and out of this bank with register-transfer accesses. It also issues data-processing commands, each carrying a 4-bit operation code and a 4-bit register index. The indexed register supplies a cycle count for the operations that need one.

Depending on the operation, the block stalls the issuing core, schedules a fast or normal interrupt request, withdraws one of those requests, or copies a free-running 32-bit cycle counter into a register. Commands arrive on a primary or a secondary command port. The secondary port accepts only the stall operation.

Every cycle in which a command is valid, the block answers with done, busy or cannot-execute. A stall holds the core for exactly the programmed number of cycles. Interrupt timers count down in the background, so several requests can be scheduled while the core keeps running.

Top module: `cvc_top`

## Requirements
- R1: After reset every register reads 0, `fiq_n` and `irq_n` are high, and the response is idle. A transfer write with `xfer_wr`=1 stores `xfer_wdata` into register `xfer_idx` at the clock edge. `xfer_rdata` always shows register `xfer_idx`.
- R2: Operation 0 (stall) answers done in its issue cycle when the indexed register holds 0.
- R3: Operation 0 with count N>0, held valid, answers busy in the issue cycle and the N-1 cycles after it, then answers done in the cycle after those. Dropping `cmd_valid` ends the stall.
- R4: Operation 1 with count N drives `fiq_n` low after the Nth clock edge that follows the issue edge. When N is 0, `fiq_n` goes low right after the issue edge.
- R5: Operation 2 does the same as R4, on `irq_n`.
- R6: Operation 3 sets `fiq_n` high after its issue edge, and operation 4 sets `irq_n` high.
- R7: Operation 5 writes the cycle counter value into the indexed register, so two captures issued K cycles apart differ by K. When a capture and a transfer write target the same register in the same cycle, the capture wins.
- R8: On the primary port, operation codes 6 to 15 answer cannot-execute. They change no register and no interrupt line.
- R9: On the secondary port (`cmd_port`=1), operation 0 behaves as on the primary port. Every nonzero code answers cannot-execute and has no effect.
- R10: Issuing operation 1 or 2 while its timer is still counting reloads the timer with the new count. The old schedule is discarded.
- R11: When a timer expires in the same cycle that the matching clear (operation 3 or 4) is issued, the clear wins. The line stays high and the timer is spent.
- R12: The response encoding is 2'b00 idle (no valid command), 2'b01 done, 2'b10 busy and 2'b11 cannot-execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_wr | input | 1 | Register-transfer write strobe |
| xfer_idx | input | 4 | Register-transfer index |
| xfer_wdata | input | 32 | Register-transfer write data |
| xfer_rdata | output | 32 | Register-transfer read data |
| cmd_valid | input | 1 | Data-processing command valid |
| cmd_port | input | 1 | 0 = primary port, 1 = secondary port |
| cmd_op | input | 4 | Operation code |
| cmd_idx | input | 4 | Register index for the operation |
| resp | output | 2 | Command response code |
| fiq_n | output | 1 | Fast interrupt request, active low |
| irq_n | output | 1 | Normal interrupt request, active low |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a timer reaching its end and a clear command for the same line. The second is a timestamp capture and a host write to the same register. The bench provokes the first pair by scheduling a fast request with a count of 2 and issuing the clear exactly two edges later. It then checks that `fiq_n` stays high for several further cycles. It provokes the second pair by issuing a capture into one register on one edge, then a capture plus a host write into another register on the next edge. It judges that pair by requiring the second register to hold the first register's value plus one, not the written data.

// File: rtl/cvc_pkg.sv
package cvc_pkg;
  typedef enum logic [1:0] {
    RSP_IDLE = 2'b00,
    RSP_DONE = 2'b01,
    RSP_BUSY = 2'b10,
    RSP_CANT = 2'b11
  } rsp_e;

  localparam logic [3:0] OP_WAIT     = 4'd0;
  localparam logic [3:0] OP_FIQ_SET  = 4'd1;
  localparam logic [3:0] OP_IRQ_SET  = 4'd2;
  localparam logic [3:0] OP_FIQ_CLR  = 4'd3;
  localparam logic [3:0] OP_IRQ_CLR  = 4'd4;
  localparam logic [3:0] OP_STAMP    = 4'd5;
endpackage

// File: rtl/cvc_regfile.sv
module cvc_regfile #(
  parameter int NREG  = 16,
  parameter int W     = 32,
  localparam int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic          cap_en,
  input  logic [IW-1:0] cap_idx,
  input  logic [W-1:0]  cap_val,
  input  logic [IW-1:0] rd_a_idx,
  output logic [W-1:0]  rd_a_data,
  input  logic [IW-1:0] rd_b_idx,
  output logic [W-1:0]  rd_b_data
);
  logic [W-1:0] mem_q [NREG];
  logic [W-1:0] mem_d [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    // capture has priority over a host write to the same slot
    always_comb begin
      mem_d[g] = mem_q[g];
      if (cap_en && cap_idx == IW'(g))
        mem_d[g] = cap_val;
      else if (wr_en && wr_idx == IW'(g))
        mem_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[g] <= '0;
      else        mem_q[g] <= mem_d[g];
    end
  end

  assign rd_a_data = mem_q[rd_a_idx];
  assign rd_b_data = mem_q[rd_b_idx];

  p_capture_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> mem_q[$past(cap_idx)] == $past(cap_val));
endmodule

// File: rtl/cvc_stall.sv
module cvc_stall #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         hold,
  input  logic [W-1:0] count,
  output logic         active,
  output logic         busy
);
  logic         act_q, act_d;
  logic [W-1:0] rem_q, rem_d;

  always_comb begin
    act_d = act_q;
    rem_d = rem_q;
    busy  = 1'b0;
    if (act_q) begin
      if (!hold || rem_q == '0) begin
        act_d = 1'b0;
      end else begin
        busy  = 1'b1;
        rem_d = rem_q - 1'b1;
      end
    end else if (start && count != '0) begin
      act_d = 1'b1;
      rem_d = count - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      rem_q <= '0;
    end else begin
      act_q <= act_d;
      rem_q <= rem_d;
    end
  end

  assign active = act_q;

  p_zero_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!act_q && start && count == '0) |=> !act_q);
  p_rem_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && hold && rem_q != '0) |=> (act_q && rem_q == $past(rem_q) - 1'b1));
endmodule

// File: rtl/cvc_irq_timer.sv
module cvc_irq_timer #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sched,
  input  logic [W-1:0] count,
  input  logic         clr,
  output logic         req_n
);
  logic         armed_q, armed_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         line_q, line_d;
  logic         fire;

  always_comb begin
    armed_d = armed_q;
    cnt_d   = cnt_q;
    fire    = 1'b0;
    if (sched) begin
      if (count == '0) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end else begin
        armed_d = 1'b1;
        cnt_d   = count;
      end
    end else if (armed_q) begin
      if (cnt_q == W'(1)) begin
        fire    = 1'b1;
        armed_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    // clear beats a coincident expiry
    line_d = line_q;
    if (clr)       line_d = 1'b1;
    else if (fire) line_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      line_q  <= 1'b1;
    end else begin
      armed_q <= armed_d;
      cnt_q   <= cnt_d;
      line_q  <= line_d;
    end
  end

  assign req_n = line_q;

  p_clear_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> req_n);
  p_fall_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_n) |-> ($past(sched && count == '0) || $past(!sched && armed_q && cnt_q == W'(1))));
endmodule

// File: rtl/cvc_top.sv
module cvc_top #(
  parameter int NREG  = 16,
  parameter int W     = 32,
  parameter int OPW   = 4,
  localparam int IW   = $clog2(NREG)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           xfer_wr,
  input  logic [IW-1:0]  xfer_idx,
  input  logic [W-1:0]   xfer_wdata,
  output logic [W-1:0]   xfer_rdata,
  input  logic           cmd_valid,
  input  logic           cmd_port,
  input  logic [OPW-1:0] cmd_op,
  input  logic [IW-1:0]  cmd_idx,
  output logic [1:0]     resp,
  output logic           fiq_n,
  output logic           irq_n
);
  import cvc_pkg::*;

  logic [W-1:0] cyc_q, cyc_d;
  logic [W-1:0] cmd_val;
  logic         legal, act;
  logic         stall_active, stall_busy;
  logic         is_wait, is_fset, is_iset, is_fclr, is_iclr, is_stamp;
  rsp_e         rsp;

  // free-running cycle counter
  assign cyc_d = cyc_q + 1'b1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_d;
  end

  // decode
  assign legal    = cmd_port ? (cmd_op == OPW'(OP_WAIT)) : (cmd_op <= OPW'(OP_STAMP));
  assign act      = cmd_valid && !stall_active && legal;
  assign is_wait  = act && cmd_op == OPW'(OP_WAIT);
  assign is_fset  = act && cmd_op == OPW'(OP_FIQ_SET);
  assign is_iset  = act && cmd_op == OPW'(OP_IRQ_SET);
  assign is_fclr  = act && cmd_op == OPW'(OP_FIQ_CLR);
  assign is_iclr  = act && cmd_op == OPW'(OP_IRQ_CLR);
  assign is_stamp = act && cmd_op == OPW'(OP_STAMP);

  cvc_regfile #(.NREG(NREG), .W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(xfer_wr), .wr_idx(xfer_idx), .wr_data(xfer_wdata),
    .cap_en(is_stamp), .cap_idx(cmd_idx), .cap_val(cyc_q),
    .rd_a_idx(xfer_idx), .rd_a_data(xfer_rdata),
    .rd_b_idx(cmd_idx), .rd_b_data(cmd_val)
  );

  cvc_stall #(.W(W)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .start(is_wait), .hold(cmd_valid), .count(cmd_val),
    .active(stall_active), .busy(stall_busy)
  );

  cvc_irq_timer #(.W(W)) u_fiq (
    .clk(clk), .rst_n(rst_n),
    .sched(is_fset), .count(cmd_val), .clr(is_fclr), .req_n(fiq_n)
  );

  cvc_irq_timer #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .sched(is_iset), .count(cmd_val), .clr(is_iclr), .req_n(irq_n)
  );

  always_comb begin
    if (!cmd_valid)                    rsp = RSP_IDLE;
    else if (stall_active)             rsp = stall_busy ? RSP_BUSY : RSP_DONE;
    else if (!legal)                   rsp = RSP_CANT;
    else if (is_wait && cmd_val != '0) rsp = RSP_BUSY;
    else                               rsp = RSP_DONE;
  end
  assign resp = rsp;

  p_idle_resp_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |-> resp == 2'b00);
  p_secondary_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !stall_active && cmd_port && cmd_op != '0) |-> resp == 2'b11);
  p_cant_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !stall_active && !cmd_port && cmd_op > 4'd5) |=> ($stable(fiq_n) && $stable(irq_n)));
endmodule

// File: tb/cvc_top_bench.sv
module cvc_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xfer_wr = 1'b0;
  logic [3:0]  xfer_idx = '0;
  logic [31:0] xfer_wdata = '0;
  logic [31:0] xfer_rdata;
  logic        cmd_valid = 1'b0;
  logic        cmd_port = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [3:0]  cmd_idx = '0;
  logic [1:0]  resp;
  logic        fiq_n, irq_n;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cvc_top u_cvc_top (
    .clk(clk), .rst_n(rst_n),
    .xfer_wr(xfer_wr), .xfer_idx(xfer_idx), .xfer_wdata(xfer_wdata), .xfer_rdata(xfer_rdata),
    .cmd_valid(cmd_valid), .cmd_port(cmd_port), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .resp(resp), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  // {idx, data}
  localparam logic [35:0] REG_TAB [6] = '{
    {4'd1, 32'hA5A5_0001}, {4'd2, 32'h0000_0004}, {4'd3, 32'h0000_0003},
    {4'd4, 32'h0000_0005}, {4'd6, 32'h0000_0002}, {4'd15, 32'hFFFF_FFFF}};

  // {port, op, idx, expected resp}; register 0 holds 0
  localparam logic [10:0] CMD_TAB [9] = '{
    {1'b0, 4'd6,  4'd0, 2'b11}, {1'b0, 4'd15, 4'd0, 2'b11},
    {1'b0, 4'd9,  4'd0, 2'b11}, {1'b1, 4'd1,  4'd0, 2'b11},
    {1'b1, 4'd5,  4'd0, 2'b11}, {1'b1, 4'd3,  4'd0, 2'b11},
    {1'b1, 4'd0,  4'd0, 2'b01}, {1'b0, 4'd0,  4'd0, 2'b01},
    {1'b0, 4'd4,  4'd0, 2'b01}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xwrite(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    xfer_wr = 1'b1; xfer_idx = idx; xfer_wdata = d;
    @(posedge clk); #1;
    xfer_wr = 1'b0;
  endtask

  task automatic xread(input logic [3:0] idx, output logic [31:0] d);
    @(negedge clk);
    xfer_idx = idx;
    #1 d = xfer_rdata;
  endtask

  // one-cycle command; returns response seen in the issue cycle
  task automatic issue(input logic port, input logic [3:0] op, input logic [3:0] idx,
                       output logic [1:0] r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_port = port; cmd_op = op; cmd_idx = idx;
    #1 r = resp;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  // after issue edge e0, line low only from e0+n on
  task automatic watch_line(input string req, input bit is_fiq, input int n, input int extra);
    for (int j = 0; j <= n + extra; j++) begin
      @(negedge clk);
      check(req, {31'd0, is_fiq ? fiq_n : irq_n}, (j >= n) ? 32'd0 : 32'd1);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] d, d2;
    logic [1:0]  r;
    int          nbusy;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state, R12 idle code
    @(negedge clk);
    check("R12 idle resp", {30'd0, resp}, 32'd0);
    check("R1 fiq_n reset", {31'd0, fiq_n}, 32'd1);
    check("R1 irq_n reset", {31'd0, irq_n}, 32'd1);
    xread(4'd9, d);
    check("R1 reg reset", d, 32'd0);

    // R1 table-driven write/read
    foreach (REG_TAB[i]) xwrite(REG_TAB[i][35:32], REG_TAB[i][31:0]);
    foreach (REG_TAB[i]) begin
      xread(REG_TAB[i][35:32], d);
      check("R1 readback", d, REG_TAB[i][31:0]);
    end

    // R8/R9/R2/R6 table of command responses
    foreach (CMD_TAB[i]) begin
      issue(CMD_TAB[i][10], CMD_TAB[i][9:6], CMD_TAB[i][5:2], r);
      check("R8 R9 R2 resp", {30'd0, r}, {30'd0, CMD_TAB[i][1:0]});
      @(negedge clk);
      check("R8 R9 no fiq", {31'd0, fiq_n}, 32'd1);
      check("R8 R9 no irq", {31'd0, irq_n}, 32'd1);
    end
    xread(4'd0, d);
    check("R9 reg0 untouched", d, 32'd0);

    // R3 stall of 4 cycles (reg2 = 4), held valid
    @(negedge clk);
    cmd_valid = 1'b1; cmd_port = 1'b0; cmd_op = 4'd0; cmd_idx = 4'd2;
    nbusy = 0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (resp == 2'b10) nbusy++;
      if (resp != 2'b10) break;
      @(negedge clk);
    end
    check("R3 busy cycles", nbusy, 32'd4);
    check("R3 done after stall", {30'd0, resp}, 32'd1);
    @(posedge clk); #1 cmd_valid = 1'b0;

    // R9 secondary stall (reg3 = 3)
    @(negedge clk);
    cmd_valid = 1'b1; cmd_port = 1'b1; cmd_idx = 4'd3;
    nbusy = 0;
    for (int k = 0; k < 12; k++) begin
      #1;
      if (resp == 2'b10) nbusy++;
      if (resp != 2'b10) break;
      @(negedge clk);
    end
    check("R9 secondary busy cycles", nbusy, 32'd3);
    @(posedge clk); #1 cmd_valid = 1'b0; cmd_port = 1'b0;

    // R4 fast request after 3 cycles, then R6 clear
    issue(1'b0, 4'd1, 4'd3, r);
    check("R4 resp done", {30'd0, r}, 32'd1);
    watch_line("R4 fiq delay", 1'b1, 3, 1);
    issue(1'b0, 4'd3, 4'd0, r);
    @(negedge clk);
    check("R6 fiq released", {31'd0, fiq_n}, 32'd1);

    // R4 N=0 immediate
    issue(1'b0, 4'd1, 4'd0, r);
    watch_line("R4 fiq immediate", 1'b1, 0, 1);
    issue(1'b0, 4'd3, 4'd0, r);

    // R5 normal request after 2 cycles, then R6 clear
    issue(1'b0, 4'd2, 4'd6, r);
    watch_line("R5 irq delay", 1'b0, 2, 1);
    issue(1'b0, 4'd4, 4'd0, r);
    @(negedge clk);
    check("R6 irq released", {31'd0, irq_n}, 32'd1);

    // R10 reload: count 5 then count 2 on next edge
    issue(1'b0, 4'd2, 4'd4, r);
    issue(1'b0, 4'd2, 4'd6, r);
    watch_line("R10 irq reload", 1'b0, 2, 4);
    issue(1'b0, 4'd4, 4'd0, r);

    // R11 clear at the expiry edge of a count-2 schedule
    issue(1'b0, 4'd1, 4'd6, r);
    @(posedge clk);
    issue(1'b0, 4'd3, 4'd0, r);
    for (int j = 0; j < 5; j++) begin
      @(negedge clk);
      check("R11 clear wins", {31'd0, fiq_n}, 32'd1);
    end

    // R7 capture spacing of 7 cycles
    issue(1'b0, 4'd5, 4'd7, r);
    repeat (6) @(posedge clk);
    issue(1'b0, 4'd5, 4'd8, r);
    xread(4'd7, d);
    xread(4'd8, d2);
    check("R7 capture spacing", d2 - d, 32'd7);

    // R7 capture vs host write same register on next edge
    issue(1'b0, 4'd5, 4'd10, r);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 4'd5; cmd_idx = 4'd11;
    xfer_wr = 1'b1; xfer_idx = 4'd11; xfer_wdata = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    cmd_valid = 1'b0; xfer_wr = 1'b0;
    xread(4'd10, d);
    xread(4'd11, d2);
    check("R7 capture beats write", d2, d + 32'd1);

    // R3 dropping valid ends stall: new stall restarts full count
    @(negedge clk);
    cmd_valid = 1'b1; cmd_idx = 4'd2; cmd_op = 4'd0;
    @(posedge clk); #1 cmd_valid = 1'b0;
    @(negedge clk);
    check("R12 idle after drop", {30'd0, resp}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule